// File: doc/BRIEF.md
# Clock Controller Register Bank

This block is the software-visible register file of a clock control unit. It decodes word accesses on a plain 32-bit bus inside a 4 KB byte window. It holds these registers:

- a mode register
- two post-divider registers
- two PLL setting registers
- three clock-enable (gating) registers
- a read-only power-management word
- a fixed constant location

Each register applies its own rules on write: a keep-mask, forced-one bits, and its own reset value. Accesses to any other word are flagged.

A frequency calculator downstream consumes the stored values. It needs to know when they change. The bank gives it a single-cycle `recalc` pulse in these cases:

- after a write to the mode, divider or PLL registers;
- once after reset is released, so the calculator starts from the reset values.

Writes to the gating registers change no frequency, so they do not raise the pulse.

Top module: `clkctl_regbank`

## Requirements
- R1: The word index is the byte address shifted right by 2, and the two low address bits are ignored. The index map is: 0 mode, 1 divider A, 2 divider B, 4 main PLL, 6 auxiliary PLL, 8/9/10 gating 0/1/2, 18 constant, 23 power management.
- R2: A write to the mode register stores the data ANDed with 0x3b6fdfff, with bit FORCE_BIT (default 2) always set to 1.
- R3: Divider A stores the write data ANDed with 0xff9f3fff. Divider B stores all 32 bits.
- R4: Both PLL registers store the write data ANDed with 0xbfff3fff. Their reset values are parameters, with default 0.
- R5: The gating registers store all 32 bits. Writing them does not pulse `recalc`.
- R6: Index 18 always reads 0x00004040, and writes to it change nothing.
- R7: Index 23 reads 0x80209828, and writes to it change nothing.
- R8: Reset values are: mode 0x074b0b7b, divider A 0xff870b48, divider B 0x49fcfe7f, each gating register 0xffffffff.
- R9: A read of an unmapped index returns 0, and a write to one is dropped. In both cases `bad_access` is high for exactly the one cycle after the access.
- R10: `bus_rdata` is registered. It is valid in the cycle after `bus_rd` and holds its value while no read is made.
- R11: A write to the mode, divider or PLL registers pulses `recalc` high for exactly the one following cycle.
- R12: `recalc` pulses once, in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address within the window |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read enable |
| bus_rdata | output | 32 | Registered read data |
| bad_access | output | 1 | One-cycle flag for an unmapped access |
| recalc | output | 1 | One-cycle request to recompute frequencies |

## Verification
The bench builds the block with its default parameters:

- ADDR_W = 12, which puts every word index 0 to 1023 within reach, including the top index and the unmapped holes between mapped words;
- FORCE_BIT = 2, whose value the bench knows;
- PLL reset values of 0.

With these values the bench can predict every readback from the masks alone, and can check that the forced bit survives a write of zero. It also drives addresses with nonzero low bits to show that they alias onto the same word.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;
  localparam int WORD_W   = 32;
  localparam int N_STORED = 8;

  typedef enum logic [3:0] {
    SLOT_CTRL  = 4'd0,
    SLOT_DIVA  = 4'd1,
    SLOT_DIVB  = 4'd2,
    SLOT_PLLM  = 4'd3,
    SLOT_PLLA  = 4'd4,
    SLOT_GATE0 = 4'd5,
    SLOT_GATE1 = 4'd6,
    SLOT_GATE2 = 4'd7,
    SLOT_PWR   = 4'd8,
    SLOT_FIXED = 4'd9,
    SLOT_NONE  = 4'd10
  } slot_e;

  localparam logic [WORD_W-1:0] FIXED_WORD = 32'h0000_4040;
  localparam logic [WORD_W-1:0] PWR_WORD   = 32'h8020_9828;
  localparam logic [WORD_W-1:0] KEEP_CTRL  = 32'h3b6f_dfff;
  localparam logic [WORD_W-1:0] KEEP_DIVA  = 32'hff9f_3fff;
  localparam logic [WORD_W-1:0] KEEP_PLL   = 32'hbfff_3fff;

  function automatic slot_e index_to_slot(input logic [31:0] widx);
    case (widx)
      32'd0:   return SLOT_CTRL;
      32'd1:   return SLOT_DIVA;
      32'd2:   return SLOT_DIVB;
      32'd4:   return SLOT_PLLM;
      32'd6:   return SLOT_PLLA;
      32'd8:   return SLOT_GATE0;
      32'd9:   return SLOT_GATE1;
      32'd10:  return SLOT_GATE2;
      32'd18:  return SLOT_FIXED;
      32'd23:  return SLOT_PWR;
      default: return SLOT_NONE;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] keep_mask(input slot_e s);
    case (s)
      SLOT_CTRL:            return KEEP_CTRL;
      SLOT_DIVA:            return KEEP_DIVA;
      SLOT_PLLM, SLOT_PLLA: return KEEP_PLL;
      default:              return '1;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] force_mask(input slot_e s, input int fbit);
    logic [WORD_W-1:0] m;
    m = '0;
    if (s == SLOT_CTRL) m[fbit] = 1'b1;
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] store_value(input slot_e s,
                                                    input logic [WORD_W-1:0] d,
                                                    input int fbit);
    return (d & keep_mask(s)) | force_mask(s, fbit);
  endfunction

  function automatic logic [WORD_W-1:0] reset_value(input slot_e s,
                                                    input logic [WORD_W-1:0] pllm,
                                                    input logic [WORD_W-1:0] plla);
    case (s)
      SLOT_CTRL: return 32'h074b_0b7b;
      SLOT_DIVA: return 32'hff87_0b48;
      SLOT_DIVB: return 32'h49fc_fe7f;
      SLOT_PLLM: return pllm;
      SLOT_PLLA: return plla;
      default:   return '1;
    endcase
  endfunction

  function automatic logic needs_recalc(input slot_e s);
    return (s == SLOT_CTRL) || (s == SLOT_DIVA) || (s == SLOT_DIVB) ||
           (s == SLOT_PLLM) || (s == SLOT_PLLA);
  endfunction

  function automatic logic is_gate(input slot_e s);
    return (s == SLOT_GATE0) || (s == SLOT_GATE1) || (s == SLOT_GATE2);
  endfunction
endpackage

// File: rtl/clkreg_decode.sv
module clkreg_decode
  import clkreg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0]   addr,
  output slot_e               slot,
  output logic                hit,
  output logic [N_STORED-1:0] match
);
  logic [31:0] widx;

  assign widx = 32'(addr) >> 2;
  assign slot = index_to_slot(widx);
  assign hit  = (slot != SLOT_NONE);

  for (genvar g = 0; g < N_STORED; g++) begin : g_match
    assign match[g] = (slot == slot_e'(g));
  end
endmodule

// File: rtl/clkreg_file.sv
module clkreg_file
  import clkreg_pkg::*;
#(
  parameter int                FORCE_BIT = 2,
  parameter logic [WORD_W-1:0] PLLM_RST  = '0,
  parameter logic [WORD_W-1:0] PLLA_RST  = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [N_STORED-1:0] match,
  input  logic [WORD_W-1:0]   wdata,
  output logic [WORD_W-1:0]   regs [N_STORED]
);
  for (genvar g = 0; g < N_STORED; g++) begin : g_reg
    localparam slot_e S = slot_e'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                regs[g] <= reset_value(S, PLLM_RST, PLLA_RST);
      else if (wr_en && match[g]) regs[g] <= store_value(S, wdata, FORCE_BIT);
    end
  end

  // R2: the forced bit is one after any mode write
  p_ctrl_force_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && match[0] |=> regs[0][FORCE_BIT]);

  // R4: cleared bits of the PLL mask stay zero after a write
  p_pll_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && match[3] |=> (regs[3] & ~KEEP_PLL) == '0);
endmodule

// File: rtl/clkreg_strobe.sv
module clkreg_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse,
  output logic boot_pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse        <= 1'b0;
      boot_pending <= 1'b1;
    end else begin
      pulse        <= trig | boot_pending;
      boot_pending <= 1'b0;
    end
  end

  // R11/R12: a pulse always has a write or the reset release behind it
  p_pulse_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(trig || boot_pending));

  // R12: the start-up request is given only once
  p_boot_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_pending |=> !boot_pending);
endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
  import clkreg_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter int                FORCE_BIT = 2,
  parameter logic [WORD_W-1:0] PLLM_RST  = '0,
  parameter logic [WORD_W-1:0] PLLA_RST  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              bad_access,
  output logic              recalc
);
  slot_e               slot;
  logic                hit;
  logic [N_STORED-1:0] match;
  logic [WORD_W-1:0]   regs [N_STORED];
  logic [WORD_W-1:0]   rd_val;
  logic                clk_write_ev;
  logic                bad_ev;
  logic                boot_pending;

  clkreg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .slot (slot),
    .hit  (hit),
    .match(match)
  );

  clkreg_file #(
    .FORCE_BIT(FORCE_BIT),
    .PLLM_RST (PLLM_RST),
    .PLLA_RST (PLLA_RST)
  ) u_file (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(bus_wr),
    .match(match),
    .wdata(bus_wdata),
    .regs (regs)
  );

  assign clk_write_ev = bus_wr && needs_recalc(slot);
  assign bad_ev       = (bus_rd || bus_wr) && !hit;

  clkreg_strobe u_strobe (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig        (clk_write_ev),
    .pulse       (recalc),
    .boot_pending(boot_pending)
  );

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < N_STORED; i++)
      if (match[i]) rd_val = regs[i];
    if (slot == SLOT_FIXED) rd_val = FIXED_WORD;
    if (slot == SLOT_PWR)   rd_val = PWR_WORD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bad_access <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_val;
      bad_access <= bad_ev;
    end
  end

  // R9: the flag follows only an access that missed the map
  p_bad_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> $past((bus_rd || bus_wr) && !hit));

  // R9: unmapped reads return zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && !hit) |-> bus_rdata == '0);

  // R5: gating writes leave the recompute request low
  p_gate_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && is_gate(slot) && !boot_pending |=> !recalc);

  // R10: read data holds without a read
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> $stable(bus_rdata));
endmodule

// File: tb/clkctl_regbank_test.sv
`timescale 1ns/1ps
module clkctl_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        bad_access;
  logic        recalc;

  always #2.5 clk = ~clk;

  clkctl_regbank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bad_access(bad_access), .recalc(recalc)
  );

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    int          idx;
    logic [31:0] val;
    string       req;
  } exp_t;
  exp_t sbq[$];

  logic [31:0] mirror [0:31];
  logic        rd_seen = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench-side restatement of the storing rules
  function automatic void model_write(input int idx, input logic [31:0] d);
    if (idx == 0) mirror[0] = {d[31:3], 1'b1, d[1:0]} & 32'h3b6f_dfff | 32'h0000_0004;
    else if (idx == 1) mirror[1] = d & 32'hff9f_3fff;
    else if (idx == 2) mirror[2] = d;
    else if (idx == 4 || idx == 6) mirror[idx] = d & 32'hbfff_3fff;
    else if (idx >= 8 && idx <= 10) mirror[idx] = d;
  endfunction

  function automatic bit recalc_expected(input int idx);
    return idx == 0 || idx == 1 || idx == 2 || idx == 4 || idx == 6;
  endfunction

  function automatic bit mapped(input int idx);
    return idx == 0 || idx == 1 || idx == 2 || idx == 4 || idx == 6 ||
           (idx >= 8 && idx <= 10) || idx == 18 || idx == 23;
  endfunction

  // monitor: compares each read result in the cycle it becomes valid
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (sbq.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R10 actual=unexpected read expected=none");
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk($sformatf("%s idx=%0d", e.req, e.idx), bus_rdata, e.val);
      end
    end
  end

  task automatic do_read(input int idx, input logic [1:0] lo, input logic [31:0] exp,
                         input string req);
    exp_t e;
    @(negedge clk);
    bus_addr = 12'(idx * 4) | 12'(lo);
    bus_rd = 1'b1;
    e.idx = idx; e.val = exp; e.req = req;
    sbq.push_back(e);
    @(negedge clk);
    bus_rd = 1'b0;
    chk({req, " R9 bad_access"}, 32'(bad_access), 32'(!mapped(idx)));
  endtask

  task automatic do_write(input int idx, input logic [31:0] d, input string req);
    @(negedge clk);
    bus_addr = 12'(idx * 4);
    bus_wdata = d;
    bus_wr = 1'b1;
    model_write(idx, d);
    @(negedge clk);
    bus_wr = 1'b0;
    chk({req, " R11 recalc"}, 32'(recalc), 32'(recalc_expected(idx)));
    chk({req, " R9 bad_access"}, 32'(bad_access), 32'(!mapped(idx)));
    @(negedge clk);
    chk({req, " R11 single pulse"}, 32'(recalc), 32'd0);
    chk({req, " R9 single flag"}, 32'(bad_access), 32'd0);
  endtask

  function automatic logic [31:0] view(input int idx);
    if (idx == 18) return 32'h0000_4040;
    if (idx == 23) return 32'h8020_9828;
    if (!mapped(idx)) return 32'h0;
    return mirror[idx];
  endfunction

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    for (int i = 0; i < 32; i++) mirror[i] = 32'h0;
    mirror[0] = 32'h074b_0b7b; mirror[1] = 32'hff87_0b48; mirror[2] = 32'h49fc_fe7f;
    mirror[8] = '1; mirror[9] = '1; mirror[10] = '1;

    repeat (3) @(negedge clk);
    chk("R10 reset rdata", bus_rdata, 32'h0);
    chk("R9 reset flag", 32'(bad_access), 32'd0);
    chk("R12 no pulse in reset", 32'(recalc), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 start-up pulse", 32'(recalc), 32'd1);
    @(negedge clk);
    chk("R12 start-up pulse ends", 32'(recalc), 32'd0);
    repeat (3) @(negedge clk);
    chk("R12 no second pulse", 32'(recalc), 32'd0);

    // R8, R4, R6, R7: reset contents
    foreach (mirror[i]) if (mapped(i)) do_read(i, 2'b00, view(i), "R8 reset value");
    do_read(18, 2'b00, 32'h0000_4040, "R6 constant");
    do_read(23, 2'b00, 32'h8020_9828, "R7 power word");

    // R2: mode register
    do_write(0, 32'hffff_ffff, "R2 mode ones");
    do_read(0, 2'b00, view(0), "R2 mode ones");
    do_write(0, 32'h0000_0000, "R2 mode zero");
    do_read(0, 2'b00, 32'h0000_0004, "R2 forced bit");

    // R3: dividers
    do_write(1, 32'hffff_ffff, "R3 divider A");
    do_read(1, 2'b00, 32'hff9f_3fff, "R3 divider A");
    do_write(2, 32'h1234_5678, "R3 divider B");
    do_read(2, 2'b00, 32'h1234_5678, "R3 divider B");

    // R4: PLLs
    do_write(4, 32'hffff_ffff, "R4 main PLL");
    do_read(4, 2'b00, 32'hbfff_3fff, "R4 main PLL");
    do_write(6, 32'h4000_c000, "R4 aux PLL");
    do_read(6, 2'b00, 32'h0000_0000, "R4 aux PLL");

    // R5: gating
    do_write(8, 32'ha5a5_5a5a, "R5 gate0");
    do_write(9, 32'h0000_0001, "R5 gate1");
    do_write(10, 32'h8000_0000, "R5 gate2");
    do_read(8, 2'b00, 32'ha5a5_5a5a, "R5 gate0");
    do_read(9, 2'b00, 32'h0000_0001, "R5 gate1");
    do_read(10, 2'b00, 32'h8000_0000, "R5 gate2");

    // R6, R7: writes ignored
    do_write(18, 32'h0, "R6 constant write");
    do_read(18, 2'b00, 32'h0000_4040, "R6 constant after write");
    do_write(23, 32'h0, "R7 power write");
    do_read(23, 2'b00, 32'h8020_9828, "R7 power after write");

    // R9: unmapped
    do_read(3, 2'b00, 32'h0, "R9 unmapped read");
    do_read(1023, 2'b00, 32'h0, "R9 top index read");
    do_write(5, 32'hdead_beef, "R9 unmapped write");
    do_write(7, 32'hdead_beef, "R9 unmapped write");
    do_read(4, 2'b00, 32'hbfff_3fff, "R9 neighbour kept");
    do_read(6, 2'b00, 32'h0000_0000, "R9 neighbour kept");
    do_read(5, 2'b00, 32'h0, "R9 dropped write");

    // R1: low address bits alias
    do_read(2, 2'b11, 32'h1234_5678, "R1 low bits ignored");
    do_read(9, 2'b10, 32'h0000_0001, "R1 low bits ignored");

    // R10: hold without reads
    do_read(0, 2'b00, 32'h0000_0004, "R10 read");
    held = bus_rdata;
    @(negedge clk); bus_addr = 12'(1 * 4);
    repeat (2) @(negedge clk);
    chk("R10 hold", bus_rdata, held);

    repeat (3) @(negedge clk);
    chk("R10 scoreboard drained", 32'(sbq.size()), 32'd0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule